// File: doc/BRIEF.md
# Bootstrap Charge Supervisor

This block sits between the commutation logic and the gate drivers of a three-phase half-bridge. Each phase has its own supervisor that decides, cycle by cycle, whether a high-side request may pass to the gate. A high side is turned on only while that phase's bootstrap capacitor is reported above its turn-on level. If the capacitor is low when the high side is wanted, or drops below its turn-off level while the high side conducts, the supervisor switches on the low side of the same phase to recharge the capacitor. It then hands over to the high side once the turn-on flag is seen.

A recharge that does not finish within `CHG_LIMIT` clock cycles is a fault. The phase's fault bit latches, the active-low fault pin goes low, and every gate enable on every phase is removed. The fault stays latched until one of three events clears it: the active-low arm input is held low, a serial read completes, or a power-on reset is signalled. The comparator flags arrive already synchronized. The block has no software-visible registers.

Top module: `hs_boot_guard`

## Requirements
- R1: From idle, a high-side request on a phase whose turn-on flag is set gives that phase's high-side enable one cycle later. The high-side enable never rises unless the turn-on flag was set in the cycle before.
- R2: A high-side request while the turn-on flag is clear turns on that phase's low-side enable one cycle later (charging). The first cycle in which the turn-on flag is seen during charging swaps to the high-side enable on the next cycle.
- R3: While the high side conducts, a set turn-off flag removes the high-side enable and turns on the low-side enable one cycle later.
- R4: A phase that stays in charging for `CHG_LIMIT` consecutive cycles without its turn-on flag sets its fault bit (bit i for phase i). In that same cycle the fault pin goes low, `out_kill` goes high, and every high-side and low-side enable of every phase is 0.
- R5: A set fault bit stays set, whatever the requests and flags do, until a clear event occurs.
- R6: Each of these, held for one cycle, clears all fault bits and returns the fault pin high on the next cycle: `arm_n` low, `rd_done` high, or `por` high.
- R7: The high-side and low-side enables of one phase are never both 1.
- R8: Dropping the high-side request during charging removes the low-side enable on the next cycle, with no fault bit set then or later.
- R9: A low-side request alone gives the low-side enable one cycle later. When both requests are present, the high-side request wins.
- R10: While `rst` is high, all enables and fault bits are 0, the fault pin is 1, and `out_kill` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm_n | input | 1 | Active-low clear; low forces every phase to idle and clears faults |
| rd_done | input | 1 | Serial-read-complete strobe; clears faults |
| por | input | 1 | Power-on reset indication; clears faults |
| hs_req | input | N_PHASE | High-side request per phase |
| ls_req | input | N_PHASE | Low-side request per phase |
| boot_ok | input | N_PHASE | Bootstrap above turn-on level, per phase |
| boot_low | input | N_PHASE | Bootstrap below turn-off level, per phase |
| hs_en | output | N_PHASE | High-side gate enable per phase |
| ls_en | output | N_PHASE | Low-side gate enable per phase |
| phase_flt | output | N_PHASE | Latched charge-timeout fault per phase |
| flt_pin_n | output | 1 | Fault pin contribution, low while any fault is latched |
| out_kill | output | 1 | Global output disable |

## Verification
The main sweep tries every phase against every charge length from zero to `CHG_LIMIT` cycles. This separates a hand-over on the last allowed cycle from a timeout one cycle later, and a miscount by one shows up as a wrong enable or a wrong fault bit. Separate patterns cover the following: a request with the capacitor already charged; a turn-off dip while the high side conducts; a request dropped mid-charge; low-only and simultaneous requests; and a timeout on one phase while another phase conducts, which shows that the fault kills the outputs globally. Each of the three clear sources is used on its own, so a clear that is wired wrongly leaves a stuck fault.

// File: rtl/boot_pkg.sv
package boot_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CHARGE = 3'd1,
        PH_HIGH   = 3'd2,
        PH_LOW    = 3'd3,
        PH_FAULT  = 3'd4
    } ph_state_t;

    // per-phase inputs after synchronization
    typedef struct packed {
        logic hs_req;
        logic ls_req;
        logic on_ok;
        logic off_low;
    } ph_in_t;

    // per-phase gate drive pair
    typedef struct packed {
        logic hs;
        logic ls;
    } ph_drv_t;

    function automatic int cnt_width(input int limit);
        return (limit > 2) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/boot_phase_fsm.sv
module boot_phase_fsm
    import boot_pkg::*;
#(
    parameter int CHG_LIMIT = 400
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    clr,
    input  logic    kill,
    input  ph_in_t  pin,
    output ph_drv_t drv,
    output logic    flt
);
    localparam int CW = cnt_width(CHG_LIMIT);
    localparam logic [CW-1:0] LAST = CW'(CHG_LIMIT - 1);

    ph_state_t     st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        if (clr) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else if (kill && st_q != PH_FAULT) begin
            st_d  = PH_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st_q)
                PH_IDLE: begin
                    cnt_d = '0;
                    if (pin.hs_req)      st_d = pin.on_ok ? PH_HIGH : PH_CHARGE;
                    else if (pin.ls_req) st_d = PH_LOW;
                end
                PH_CHARGE: begin
                    if (!pin.hs_req)     st_d = pin.ls_req ? PH_LOW : PH_IDLE;
                    else if (pin.on_ok)  st_d = PH_HIGH;
                    else if (cnt_q == LAST) st_d = PH_FAULT;
                    else                 cnt_d = cnt_q + 1'b1;
                end
                PH_HIGH: begin
                    cnt_d = '0;
                    if (!pin.hs_req)      st_d = pin.ls_req ? PH_LOW : PH_IDLE;
                    else if (pin.off_low) st_d = PH_CHARGE;
                end
                PH_LOW: begin
                    cnt_d = '0;
                    if (pin.hs_req)       st_d = pin.on_ok ? PH_HIGH : PH_CHARGE;
                    else if (!pin.ls_req) st_d = PH_IDLE;
                end
                PH_FAULT: st_d = PH_FAULT;
                default:  st_d = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PH_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    always_comb begin
        drv.hs = (st_q == PH_HIGH) && !kill;
        drv.ls = (st_q == PH_CHARGE || st_q == PH_LOW) && !kill;
        flt    = (st_q == PH_FAULT);
    end

endmodule

// File: rtl/boot_fault_merge.sv
module boot_fault_merge #(
    parameter int N_PHASE = 3
) (
    input  logic [N_PHASE-1:0] flt,
    input  logic               arm_n,
    input  logic               rd_done,
    input  logic               por,
    output logic               clr,
    output logic               kill,
    output logic               pin_n
);
    always_comb begin
        clr   = !arm_n || rd_done || por;
        kill  = |flt;
        pin_n = !kill;
    end
endmodule

// File: rtl/hs_boot_guard.sv
module hs_boot_guard
    import boot_pkg::*;
#(
    parameter int N_PHASE   = 3,
    parameter int CHG_LIMIT = 400
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               arm_n,
    input  logic               rd_done,
    input  logic               por,
    input  logic [N_PHASE-1:0] hs_req,
    input  logic [N_PHASE-1:0] ls_req,
    input  logic [N_PHASE-1:0] boot_ok,
    input  logic [N_PHASE-1:0] boot_low,
    output logic [N_PHASE-1:0] hs_en,
    output logic [N_PHASE-1:0] ls_en,
    output logic [N_PHASE-1:0] phase_flt,
    output logic               flt_pin_n,
    output logic               out_kill
);
    logic clr, kill;

    boot_fault_merge #(.N_PHASE(N_PHASE)) u_merge (
        .flt     (phase_flt),
        .arm_n   (arm_n),
        .rd_done (rd_done),
        .por     (por),
        .clr     (clr),
        .kill    (kill),
        .pin_n   (flt_pin_n)
    );

    assign out_kill = kill;

    for (genvar i = 0; i < N_PHASE; i++) begin : g_ph
        ph_in_t  pin;
        ph_drv_t drv;
        assign pin = '{hs_req: hs_req[i], ls_req: ls_req[i],
                       on_ok: boot_ok[i], off_low: boot_low[i]};
        boot_phase_fsm #(.CHG_LIMIT(CHG_LIMIT)) u_fsm (
            .clk  (clk),
            .rst  (rst),
            .clr  (clr),
            .kill (kill),
            .pin  (pin),
            .drv  (drv),
            .flt  (phase_flt[i])
        );
        assign hs_en[i] = drv.hs;
        assign ls_en[i] = drv.ls;
    end

endmodule

// File: rtl/boot_guard_chk.sv
module boot_guard_chk #(
    parameter int N_PHASE = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               arm_n,
    input logic               rd_done,
    input logic               por,
    input logic [N_PHASE-1:0] boot_ok,
    input logic [N_PHASE-1:0] hs_en,
    input logic [N_PHASE-1:0] ls_en,
    input logic [N_PHASE-1:0] phase_flt,
    input logic               flt_pin_n,
    input logic               out_kill
);
    logic clr_ev;
    assign clr_ev = !arm_n || rd_done || por;

    for (genvar i = 0; i < N_PHASE; i++) begin : g_a
        assert_no_overlap_R7: assert property (@(posedge clk) disable iff (rst)
            !(hs_en[i] && ls_en[i]));
        assert_hs_needs_ok_R1: assert property (@(posedge clk) disable iff (rst)
            $rose(hs_en[i]) |-> $past(boot_ok[i]));
        assert_flt_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (phase_flt[i] && !clr_ev) |=> phase_flt[i]);
        assert_flt_from_charge_R4: assert property (@(posedge clk) disable iff (rst)
            $rose(phase_flt[i]) |-> $past(ls_en[i]));
    end

    assert_clear_R6: assert property (@(posedge clk) disable iff (rst)
        clr_ev |=> (phase_flt == '0 && flt_pin_n));
    assert_kill_R4: assert property (@(posedge clk) disable iff (rst)
        out_kill |-> (hs_en == '0 && ls_en == '0 && !flt_pin_n));
    assert_pin_R4: assert property (@(posedge clk) disable iff (rst)
        (phase_flt != '0) |-> (out_kill && !flt_pin_n));
    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (phase_flt == '0 && flt_pin_n));
endmodule

bind hs_boot_guard boot_guard_chk #(.N_PHASE(N_PHASE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm_n     (arm_n),
    .rd_done   (rd_done),
    .por       (por),
    .boot_ok   (boot_ok),
    .hs_en     (hs_en),
    .ls_en     (ls_en),
    .phase_flt (phase_flt),
    .flt_pin_n (flt_pin_n),
    .out_kill  (out_kill)
);

// File: tb/sim_hs_boot_guard.sv
`timescale 1ns/1ps
module sim_hs_boot_guard;
    localparam int N = 3;
    localparam int T = 6;

    logic clk = 1'b0;
    logic rst, arm_n, rd_done, por;
    logic [N-1:0] hs_req, ls_req, boot_ok, boot_low;
    logic [N-1:0] hs_en, ls_en, phase_flt;
    logic flt_pin_n, out_kill;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    hs_boot_guard #(.N_PHASE(N), .CHG_LIMIT(T)) u0 (
        .clk(clk), .rst(rst), .arm_n(arm_n), .rd_done(rd_done), .por(por),
        .hs_req(hs_req), .ls_req(ls_req), .boot_ok(boot_ok), .boot_low(boot_low),
        .hs_en(hs_en), .ls_en(ls_en), .phase_flt(phase_flt),
        .flt_pin_n(flt_pin_n), .out_kill(out_kill)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
        chk("R7 overlap", 32'(hs_en & ls_en), 32'd0);
    endtask

    task automatic drv(input logic [N-1:0] hs, input logic [N-1:0] okv);
        hs_req  = hs;
        boot_ok = okv;
    endtask

    task automatic clear_by(input int how);
        case (how)
            0: arm_n = 1'b0;
            1: rd_done = 1'b1;
            default: por = 1'b1;
        endcase
        step();
        arm_n = 1'b1; rd_done = 1'b0; por = 1'b0;
        chk("R6 fault cleared", 32'(phase_flt), 32'd0);
        chk("R6 pin high", 32'(flt_pin_n), 32'd1);
    endtask

    initial begin
        rst = 1'b1; arm_n = 1'b1; rd_done = 1'b0; por = 1'b0;
        hs_req = '0; ls_req = '0; boot_ok = '0; boot_low = '0;
        step(); step();
        chk("R10 hs", 32'(hs_en), 0);
        chk("R10 ls", 32'(ls_en), 0);
        chk("R10 flt", 32'(phase_flt), 0);
        chk("R10 pin", 32'({flt_pin_n, out_kill}), 32'b10);
        rst = 1'b0;
        step();

        // sweep every phase and every charge length 0..T
        for (int p = 0; p < N; p++) begin
            for (int m = 0; m <= T; m++) begin
                drv(N'(1 << p), '0);
                step();
                chk("R2 charge start", 32'(ls_en), 32'(1 << p));
                chk("R2 no hs", 32'(hs_en), 0);
                for (int s = 1; s <= m; s++) begin
                    step();
                    if (s < T) begin
                        chk("R2 charging", 32'(ls_en), 32'(1 << p));
                        chk("R4 no early fault", 32'(phase_flt), 0);
                    end else begin
                        chk("R4 fault bit", 32'(phase_flt), 32'(1 << p));
                        chk("R4 pin/kill", 32'({flt_pin_n, out_kill}), 32'b01);
                        chk("R4 outputs off", 32'({hs_en, ls_en}), 0);
                    end
                end
                if (m < T) begin
                    boot_ok = N'(1 << p);
                    step();
                    chk("R2 handover hs", 32'(hs_en), 32'(1 << p));
                    chk("R2 handover ls", 32'(ls_en), 0);
                    drv('0, '0);
                    step();
                    chk("R1 release", 32'(hs_en), 0);
                end else begin
                    drv('0, '0);
                    ls_req = '1; boot_ok = '1;
                    step(); step();
                    chk("R5 latched", 32'(phase_flt), 32'(1 << p));
                    chk("R5 outputs off", 32'({hs_en, ls_en}), 0);
                    ls_req = '0; boot_ok = '0;
                    clear_by(p);
                    step();
                end
            end
        end

        // R1: charged capacitor gives immediate high side
        for (int p = 0; p < N; p++) begin
            drv(N'(1 << p), N'(1 << p));
            step();
            chk("R1 direct hs", 32'(hs_en), 32'(1 << p));
            chk("R1 no ls", 32'(ls_en), 0);
            // R3: turn-off dip recharges
            boot_ok = '0; boot_low = N'(1 << p);
            step();
            chk("R3 hs off", 32'(hs_en), 0);
            chk("R3 recharge", 32'(ls_en), 32'(1 << p));
            boot_ok = N'(1 << p); boot_low = '0;
            step();
            chk("R3 hs back", 32'(hs_en), 32'(1 << p));
            drv('0, '0);
            step();
        end

        // R8: drop request mid-charge
        drv(3'b010, '0);
        step(); step(); step();
        hs_req = '0;
        step();
        chk("R8 ls off", 32'(ls_en), 0);
        for (int k = 0; k < T + 2; k++) step();
        chk("R8 no fault", 32'(phase_flt), 0);

        // R9: low side alone, then priority
        ls_req = 3'b100;
        step();
        chk("R9 ls only", 32'(ls_en), 32'b100);
        hs_req = 3'b100; boot_ok = 3'b100;
        step();
        chk("R9 hs wins", 32'({hs_en, ls_en}), 32'b100_000);
        hs_req = '0; boot_ok = '0; ls_req = '0;
        step();

        // R4: timeout on phase 1 kills conducting phase 0
        drv(3'b001, 3'b001);
        step();
        chk("R4 ph0 on", 32'(hs_en), 32'b001);
        hs_req = 3'b011;
        step();
        for (int s = 1; s < T; s++) step();
        chk("R4 ph0 still on", 32'(hs_en), 32'b001);
        step();
        chk("R4 kill global", 32'({hs_en, ls_en}), 0);
        chk("R4 ph1 fault", 32'(phase_flt), 32'b010);
        drv('0, '0);
        clear_by(1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule